// File: doc/BRIEF.md
# Multi-Transform Result Combiner and Job Sequencer

This block sits behind four real-valued triple-product channels. Each channel delivers one of the four cross products of the real and imaginary coefficient parts around an input matrix: real·X·real, real·X·imag, imag·X·real and imag·X·imag. A three-bit transform code picks one of five jobs: DFT, DCT, DST, one-dimensional DWT or two-dimensional DWT. For the sinusoidal transforms the block subtracts or adds channel pairs to form the real and imaginary results. For wavelets it forwards the two cross channels unchanged. For the 2-D DWT it also raises the select of the 2:1 multiplexer that feeds the first array's output into the second array.

A job starts with a one-cycle start pulse while the block is idle. The transform code is captured at that moment and held until the job ends. The sequencer counts `JOB_LEN` valid channel beats per stage. It runs a second stage only for the 2-D DWT, raises done for one cycle and returns to idle. Jobs are strictly serial: a start pulse during a job is ignored. Both result lanes are saturated to `OUT_W` signed bits and registered, so each lane's valid flag follows its input beat by one clock.

Top module: `mtx_combine_ctrl`

## Requirements
- R1: During and right after synchronous reset, busy_o, done_o, err_o, chain_sel_o, res_a_vld_o and res_b_vld_o are all 0.
- R2: The transform codes are 0 = DFT, 1 = DCT, 2 = DST, 3 = 1-D DWT and 4 = 2-D DWT. A start pulse in idle carrying code 5, 6 or 7 raises err_o for exactly the next cycle and starts no job. busy_o stays 0 and no result is emitted.
- R3: In DFT and DCT jobs, lane A carries sat(rr − ii) one clock after each accepted beat.
- R4: In DFT and DST jobs, lane B carries sat(ri + ir) one clock after each accepted beat.
- R5: Lane B is never valid in a DCT job and lane A is never valid in a DST job. Both lanes are valid for every accepted beat of DFT and 1-D DWT jobs.
- R6: In DWT jobs, lane A carries sat(ri) and lane B carries sat(ir), with no combining.
- R7: chain_sel_o is 1 from the cycle after a 2-D DWT start up to and including its done cycle. It is 0 for every other job and in idle.
- R8: A 2-D DWT job takes two stages of JOB_LEN beats each. Only second-stage beats produce results, and done_o does not rise between the stages.
- R9: The transform code is captured at start. Changes on mode_i, and start pulses, while busy_o is 1 have no effect on the running job.
- R10: done_o is 1 for exactly the one cycle after the last counted beat. The block is idle in the cycle after that. Beats with ch_valid_i low, or beats outside a run stage, produce no result.
- R11: All results saturate to the signed OUT_W range [−2^(OUT_W−1), 2^(OUT_W−1)−1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Job start pulse, accepted only when idle |
| mode_i | input | 3 | Transform code, sampled at start |
| ch_valid_i | input | 1 | All four channel samples valid this cycle |
| ch_rr_i | input | IN_W | Real·X·real channel sample (signed) |
| ch_ri_i | input | IN_W | Real·X·imag channel sample (signed) |
| ch_ir_i | input | IN_W | Imag·X·real channel sample (signed) |
| ch_ii_i | input | IN_W | Imag·X·imag channel sample (signed) |
| busy_o | output | 1 | A job is in progress (including its done cycle) |
| done_o | output | 1 | One-cycle end-of-job flag |
| err_o | output | 1 | One-cycle flag for a rejected transform code |
| chain_sel_o | output | 1 | Second-array input select: 1 = first array output, 0 = external |
| res_a_o | output | OUT_W | Lane A result (difference or first cross channel) |
| res_a_vld_o | output | 1 | Lane A result valid |
| res_b_o | output | OUT_W | Lane B result (sum or second cross channel) |
| res_b_vld_o | output | 1 | Lane B result valid |

## Verification
The bench builds the block with IN_W = 5, OUT_W = 4 and JOB_LEN = 1024. With these values every beat index of a job maps to a distinct channel pair. Each job therefore sweeps all 1024 combinations of (rr, ii) and of (ri, ir), which covers every positive and negative saturation case of the subtractor and the adder. Because the input is one bit wider than the output, passthrough clamping is also reached. Every transform code runs as a full job, the three rejected codes are tried, and the runs include mid-job start and mode disturbances, input bubbles and a beat arriving in the done cycle.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [2:0] {
    XF_DFT  = 3'd0,
    XF_DCT  = 3'd1,
    XF_DST  = 3'd2,
    XF_DWT1 = 3'd3,
    XF_DWT2 = 3'd4
  } xform_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_STAGE1 = 2'd1,
    S_STAGE2 = 2'd2,
    S_DONE   = 2'd3
  } seq_state_e;

  // datapath steering for one job
  typedef struct packed {
    logic a_en;    // lane A emits results
    logic b_en;    // lane B emits results
    logic a_diff;  // lane A = rr - ii, else ri passthrough
    logic b_sum;   // lane B = ri + ir, else ir passthrough
  } dp_ctl_t;

endpackage

// File: rtl/mtx_mode_dec.sv
module mtx_mode_dec
  import mtx_pkg::*;
(
  input  logic [2:0] code_i,
  output dp_ctl_t    dp_o,
  output logic       chain_o,
  output logic       ok_o
);

  always_comb begin
    dp_o    = '0;
    chain_o = 1'b0;
    ok_o    = 1'b1;
    case (code_i)
      XF_DFT:  dp_o = '{a_en: 1'b1, b_en: 1'b1, a_diff: 1'b1, b_sum: 1'b1};
      XF_DCT:  dp_o = '{a_en: 1'b1, b_en: 1'b0, a_diff: 1'b1, b_sum: 1'b1};
      XF_DST:  dp_o = '{a_en: 1'b0, b_en: 1'b1, a_diff: 1'b1, b_sum: 1'b1};
      XF_DWT1: dp_o = '{a_en: 1'b1, b_en: 1'b1, a_diff: 1'b0, b_sum: 1'b0};
      XF_DWT2: begin
        dp_o    = '{a_en: 1'b1, b_en: 1'b1, a_diff: 1'b0, b_sum: 1'b0};
        chain_o = 1'b1;
      end
      default: ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mtx_sat_addsub.sv
module mtx_sat_addsub #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter bit SUB   = 1'b0
) (
  input  logic signed [IN_W-1:0]  a_i,
  input  logic signed [IN_W-1:0]  b_i,
  output logic signed [OUT_W-1:0] y_o
);

  localparam int SW = ((IN_W + 1) > OUT_W) ? (IN_W + 2) : (OUT_W + 1);
  localparam logic signed [SW-1:0] HI = SW'((longint'(1) <<< (OUT_W - 1)) - longint'(1));
  localparam logic signed [SW-1:0] LO = ~HI;

  logic signed [SW-1:0] ea, eb, s;

  assign ea = SW'(a_i);
  assign eb = SW'(b_i);

  generate
    if (SUB) begin : g_sub
      assign s = ea - eb;
    end else begin : g_add
      assign s = ea + eb;
    end
  endgenerate

  always_comb begin
    if (s > HI)      y_o = HI[OUT_W-1:0];
    else if (s < LO) y_o = LO[OUT_W-1:0];
    else             y_o = s[OUT_W-1:0];
  end

endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
  import mtx_pkg::*;
#(
  parameter int JOB_LEN = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start_i,
  input  logic    ok_i,
  input  dp_ctl_t dp_i,
  input  logic    chain_i,
  input  logic    beat_i,
  output dp_ctl_t dp_q_o,
  output logic    emit_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    err_o,
  output logic    chain_o
);

  localparam int CW = (JOB_LEN > 1) ? $clog2(JOB_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(JOB_LEN - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  dp_ctl_t       dp_q;
  logic          chain_q, err_q;
  logic          running, last_beat;

  assign running   = (state_q == S_STAGE1) || (state_q == S_STAGE2);
  assign last_beat = running && beat_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      dp_q    <= '0;
      chain_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (start_i) begin
            if (ok_i) begin
              state_q <= S_STAGE1;
              dp_q    <= dp_i;
              chain_q <= chain_i;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        S_STAGE1: begin
          if (beat_i) cnt_q <= cnt_q + 1'b1;
          if (last_beat) begin
            cnt_q   <= '0;
            state_q <= chain_q ? S_STAGE2 : S_DONE;
          end
        end
        S_STAGE2: begin
          if (beat_i) cnt_q <= cnt_q + 1'b1;
          if (last_beat) begin
            cnt_q   <= '0;
            state_q <= S_DONE;
          end
        end
        default: begin
          state_q <= S_IDLE;
          chain_q <= 1'b0;
        end
      endcase
    end
  end

  assign emit_o  = beat_i && ((state_q == S_STAGE2) || ((state_q == S_STAGE1) && !chain_q));
  assign dp_q_o  = dp_q;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_DONE);
  assign err_o   = err_q;
  assign chain_o = chain_q;

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);
  a_r2_err_no_job: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o);
  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> ($stable(dp_q) && $stable(chain_q)));
  a_r8_stage2_only_2d: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_STAGE2) |-> chain_q);

endmodule

// File: rtl/mtx_combine_ctrl.sv
module mtx_combine_ctrl
  import mtx_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 16,
  parameter int JOB_LEN = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [2:0]              mode_i,
  input  logic                    ch_valid_i,
  input  logic signed [IN_W-1:0]  ch_rr_i,
  input  logic signed [IN_W-1:0]  ch_ri_i,
  input  logic signed [IN_W-1:0]  ch_ir_i,
  input  logic signed [IN_W-1:0]  ch_ii_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    chain_sel_o,
  output logic signed [OUT_W-1:0] res_a_o,
  output logic                    res_a_vld_o,
  output logic signed [OUT_W-1:0] res_b_o,
  output logic                    res_b_vld_o
);

  localparam logic signed [IN_W-1:0] ZERO = '0;

  dp_ctl_t dec_dp, dp_q;
  logic    dec_chain, dec_ok, emit;

  mtx_mode_dec u_dec (
    .code_i  (mode_i),
    .dp_o    (dec_dp),
    .chain_o (dec_chain),
    .ok_o    (dec_ok)
  );

  mtx_seq #(.JOB_LEN(JOB_LEN)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ok_i    (dec_ok),
    .dp_i    (dec_dp),
    .chain_i (dec_chain),
    .beat_i  (ch_valid_i),
    .dp_q_o  (dp_q),
    .emit_o  (emit),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .chain_o (chain_sel_o)
  );

  logic signed [OUT_W-1:0] diff_y, sum_y, pass_a_y, pass_b_y;

  mtx_sat_addsub #(.IN_W(IN_W), .OUT_W(OUT_W), .SUB(1'b1)) u_diff (
    .a_i (ch_rr_i), .b_i (ch_ii_i), .y_o (diff_y));
  mtx_sat_addsub #(.IN_W(IN_W), .OUT_W(OUT_W), .SUB(1'b0)) u_sum (
    .a_i (ch_ri_i), .b_i (ch_ir_i), .y_o (sum_y));
  mtx_sat_addsub #(.IN_W(IN_W), .OUT_W(OUT_W), .SUB(1'b0)) u_pass_a (
    .a_i (ch_ri_i), .b_i (ZERO), .y_o (pass_a_y));
  mtx_sat_addsub #(.IN_W(IN_W), .OUT_W(OUT_W), .SUB(1'b0)) u_pass_b (
    .a_i (ch_ir_i), .b_i (ZERO), .y_o (pass_b_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a_vld_o <= 1'b0;
      res_b_vld_o <= 1'b0;
      res_a_o     <= '0;
      res_b_o     <= '0;
    end else begin
      res_a_vld_o <= emit && dp_q.a_en;
      res_b_vld_o <= emit && dp_q.b_en;
      if (emit && dp_q.a_en) res_a_o <= dp_q.a_diff ? diff_y : pass_a_y;
      if (emit && dp_q.b_en) res_b_o <= dp_q.b_sum ? sum_y : pass_b_y;
    end
  end

  a_r10_valid_in_job: assert property (@(posedge clk) disable iff (rst)
    (res_a_vld_o || res_b_vld_o) |-> busy_o);
  a_r7_chain_in_job: assert property (@(posedge clk) disable iff (rst)
    chain_sel_o |-> busy_o);
  a_r7_chain_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> $stable(chain_sel_o));
  a_r2_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

endmodule

// File: tb/mtx_combine_ctrl_tb_top.sv
module mtx_combine_ctrl_tb_top;

  localparam int IN_W    = 5;
  localparam int OUT_W   = 4;
  localparam int JOB_LEN = 1024;
  localparam int IMOD    = 1 << IN_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic                    start_i = 1'b0;
  logic [2:0]              mode_i = '0;
  logic                    ch_valid_i = 1'b0;
  logic signed [IN_W-1:0]  ch_rr_i = '0, ch_ri_i = '0, ch_ir_i = '0, ch_ii_i = '0;
  logic                    busy_o, done_o, err_o, chain_sel_o;
  logic signed [OUT_W-1:0] res_a_o, res_b_o;
  logic                    res_a_vld_o, res_b_vld_o;

  mtx_combine_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .JOB_LEN(JOB_LEN)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .ch_valid_i(ch_valid_i), .ch_rr_i(ch_rr_i), .ch_ri_i(ch_ri_i),
    .ch_ir_i(ch_ir_i), .ch_ii_i(ch_ii_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .chain_sel_o(chain_sel_o), .res_a_o(res_a_o),
    .res_a_vld_o(res_a_vld_o), .res_b_o(res_b_o), .res_b_vld_o(res_b_vld_o));

  int n_chk = 0;
  int n_fail = 0;

  function automatic int sx(int v);
    return (v >= IMOD / 2) ? v - IMOD : v;
  endfunction

  function automatic int satv(int v);
    int hi = (1 << (OUT_W - 1)) - 1;
    int lo = -(1 << (OUT_W - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int rr_of(int k); return sx(k % IMOD); endfunction
  function automatic int ii_of(int k); return sx((k / IMOD) % IMOD); endfunction
  function automatic int ri_of(int k); return sx((k / IMOD) % IMOD); endfunction
  function automatic int ir_of(int k); return sx(k % IMOD); endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle of stimulus; returns 1 ns after the capturing edge
  task automatic cyc(bit vld, int k, bit st, int md);
    @(negedge clk);
    start_i    = st;
    mode_i     = 3'(md);
    ch_valid_i = vld;
    ch_rr_i    = IN_W'(rr_of(k));
    ch_ii_i    = IN_W'(ii_of(k));
    ch_ri_i    = IN_W'(ri_of(k));
    ch_ir_i    = IN_W'(ir_of(k));
    @(posedge clk);
    #1;
  endtask

  task automatic run_job(int md);
    int nst = (md == 4) ? 2 : 1;
    cyc(1'b0, 0, 1'b1, md);
    chk("R9 busy after start", int'(busy_o), 1);
    chk("R7 chain select at start", int'(chain_sel_o), (md == 4) ? 1 : 0);
    for (int s = 0; s < nst; s++) begin
      for (int k = 0; k < JOB_LEN; k++) begin
        bit emits = (md != 4) || (s == 1);
        bit ea = emits && (md != 2);
        bit eb = emits && (md != 1);
        int dmd = md;
        bit dst = 1'b0;
        if (md == 0 && (k % 97) == 50) begin
          cyc(1'b0, k + 7, 1'b0, md);
          chk("R10 bubble gives no lane A", int'(res_a_vld_o), 0);
          chk("R10 bubble gives no lane B", int'(res_b_vld_o), 0);
        end
        if (md == 1 && k >= 100) dmd = 2;
        if (md == 1 && k == 100) dst = 1'b1;
        if (md == 3 && k == 300) begin dmd = 0; dst = 1'b1; end
        cyc(1'b1, k, dst, dmd);
        chk("R5 lane A valid", int'(res_a_vld_o), int'(ea));
        chk("R5 lane B valid", int'(res_b_vld_o), int'(eb));
        if (ea) begin
          if (md <= 1) chk("R3 R11 lane A difference", int'(res_a_o), satv(rr_of(k) - ii_of(k)));
          else         chk("R6 R11 lane A passthrough", int'(res_a_o), satv(ri_of(k)));
        end
        if (eb) begin
          if (md <= 2) chk("R4 R11 lane B sum", int'(res_b_o), satv(ri_of(k) + ir_of(k)));
          else         chk("R6 R11 lane B passthrough", int'(res_b_o), satv(ir_of(k)));
        end
        if (k == JOB_LEN - 1) begin
          chk("R10 R8 done after last beat", int'(done_o), (s == nst - 1) ? 1 : 0);
          chk("R7 chain held", int'(chain_sel_o), (md == 4) ? 1 : 0);
        end
      end
    end
    // a beat during the done cycle is ignored
    cyc(1'b1, 9, 1'b0, md);
    chk("R10 no lane A after done", int'(res_a_vld_o), 0);
    chk("R10 no lane B after done", int'(res_b_vld_o), 0);
    chk("R10 single done", int'(done_o), 0);
    chk("R10 idle after done", int'(busy_o), 0);
    chk("R7 chain released", int'(chain_sel_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 chain", int'(chain_sel_o), 0);
    chk("R1 lane A valid", int'(res_a_vld_o), 0);
    chk("R1 lane B valid", int'(res_b_vld_o), 0);

    for (int c = 5; c <= 7; c++) begin
      cyc(1'b0, 0, 1'b1, c);
      chk("R2 err on bad code", int'(err_o), 1);
      chk("R2 no job on bad code", int'(busy_o), 0);
      cyc(1'b1, 3, 1'b0, c);
      chk("R2 err single cycle", int'(err_o), 0);
      chk("R2 still idle", int'(busy_o), 0);
      chk("R2 no result", int'(res_a_vld_o | res_b_vld_o), 0);
    end

    for (int m = 0; m <= 4; m++) run_job(m);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule